// File: doc/BRIEF.md
# Pin-Change and External Interrupt Unit

This block turns activity on a small microcontroller port into interrupt requests. There are six pin-change inputs and one dedicated external input. A mask bit on each pin-change input decides whether a toggle on that pin counts. Any toggle on an unmasked pin, in either direction, sets one shared sticky flag. The external input has a two-bit sense selector that picks low level, falling edge, rising edge or any change. Each source has an enable that gates its request output. Sticky flags clear when the CPU acknowledges the interrupt or when software writes one to the flag.

The pins are sampled as they are, whatever the port's data direction. A pin that the port itself drives can therefore raise its own interrupt, which gives a way to make a software interrupt. Edge sensing on the external input depends on the I/O clock. Pin-change detection and low-level detection do not, so either of them can wake the part from power-down, where the I/O clock is stopped.

A wake starts a start-up timer that counts a fixed number of system-clock cycles. No interrupt request leaves the block until the timer ends. A low level that caused the wake only produces an interrupt if the pin is still low when the timer ends. Otherwise the part wakes up and no interrupt is raised.

Top module: `pin_irq_unit`

## Requirements
- R1: A toggle in either direction on a pin-change input whose mask bit is 1 sets `pc_flag_o` three clock edges after the pin changes. A toggle on a masked pin (mask bit 0) leaves the flag at 0.
- R2: `pc_irq_o` is high exactly when the pin-change flag is set, `pc_en_i` is 1 and the block is running (`ready_o` = 1).
- R3: The external sense selector uses 2'b01 for any change, 2'b10 for a falling edge and 2'b11 for a rising edge. A matching edge sets `ext_flag_o` three clock edges after the pin changes. An edge that does not match leaves the flag clear.
- R4: The external edge flag does not set while the I/O clock is off. The I/O clock is off when `io_clk_en_i` is 0 or the block is in power-down or start-up. An edge that happens while the clock is off is lost, and it is not recognised when the clock comes back.
- R5: With sense 2'b00 and `ext_en_i` = 1, `ext_irq_o` follows the pin while the block runs. It goes high two edges after the pin goes low and drops two edges after the pin goes high. Nothing is latched.
- R6: Each sticky flag clears on the clock edge at which its acknowledge input or its write-one-clear input is 1.
- R7: In power-down, `wake_o` rises when the pin-change flag is set with `pc_en_i` = 1, or when the external pin is low with sense 2'b00 and `ext_en_i` = 1. This works with `io_clk_en_i` = 0.
- R8: A pulse on `pd_enter_i` puts the block into power-down (`ready_o` = 0). After a wake it stays in start-up for STARTUP_CYC cycles, and `ready_o` returns to 1 when those cycles end. Both request outputs stay low throughout power-down and start-up.
- R9: After a low-level wake, `ext_irq_o` rises only if the pin is still low when start-up ends. If the pin has gone high by then, the block wakes and `ext_irq_o` stays 0.
- R10: After reset both flags and both request outputs are 0, `wake_o` is 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It keeps running in every sleep state. |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_clk_en_i | input | 1 | I/O clock running. This is 0 in sleep states deeper than idle. |
| pd_enter_i | input | 1 | One-cycle pulse that enters power-down |
| pc_pins_i | input | 6 | Pin-change input pins |
| pc_mask_i | input | 6 | Per-pin mask. A 1 lets that pin's toggles count. |
| pc_en_i | input | 1 | Pin-change request enable |
| pc_ack_i | input | 1 | Pin-change interrupt acknowledge |
| pc_w1c_i | input | 1 | Software write of one to the pin-change flag |
| ext_pin_i | input | 1 | Dedicated external interrupt pin |
| ext_sense_i | input | 2 | Sense select: 00 low level, 01 any change, 10 falling edge, 11 rising edge |
| ext_en_i | input | 1 | External request enable |
| ext_ack_i | input | 1 | External interrupt acknowledge |
| ext_w1c_i | input | 1 | Software write of one to the external flag |
| pc_irq_o | output | 1 | Pin-change interrupt request |
| ext_irq_o | output | 1 | External interrupt request |
| pc_flag_o | output | 1 | Sticky pin-change flag |
| ext_flag_o | output | 1 | Sticky external edge flag |
| wake_o | output | 1 | Wake request while in power-down |
| ready_o | output | 1 | Running, with start-up complete |

## Verification
Random pin patterns are driven under random masks. Some patterns toggle only masked pins, some toggle several pins at once, and some rise and fall at the same time. This separates correct mask gating and direction-blind toggle sensing from an OR taken over the raw pins. Random values on the external pin under the three edge senses, with the I/O clock randomly on or off, separate the rising, falling and any-change decode from each other and from clock gating. Directed power-down runs pit a low level that holds through start-up against one that goes away before start-up ends, and check a pin-change wake and an edge that is lost during sleep.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_t;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_WARM  = 2'b10
  } pwr_t;

  // Edge decode for the clocked sense modes; level mode never yields an edge.
  function automatic logic edge_hit(input sense_t s, input logic prev, input logic cur);
    case (s)
      SENSE_ANY:  edge_hit = prev ^ cur;
      SENSE_FALL: edge_hit = prev & ~cur;
      SENSE_RISE: edge_hit = ~prev & cur;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  // Toggle vector restricted to unmasked pins.
  function automatic logic [31:0] masked_toggle(input logic [31:0] prev,
                                                input logic [31:0] cur,
                                                input logic [31:0] mask);
    masked_toggle = (prev ^ cur) & mask;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pc_detect.sv
module pc_detect
  import pin_irq_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_s,
  input  logic [N-1:0] mask,
  input  logic         clr,
  output logic [N-1:0] toggle,
  output logic         flag
);
  logic [N-1:0] prev;

  assign toggle = N'(masked_toggle(32'(prev), 32'(pins_s), 32'(mask)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      flag <= 1'b0;
    end else begin
      prev <= pins_s;
      if (|toggle)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !(|toggle) |=> !flag);
endmodule

// File: rtl/ext_sense.sv
module ext_sense
  import pin_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_t sense,
  input  logic   io_on,
  input  logic   clr,
  output logic   hit,
  output logic   flag
);
  logic prev;

  // prev follows every system clock, so edges seen while the I/O clock is off are dropped
  assign hit = io_on & edge_hit(sense, prev, pin_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
      flag <= 1'b0;
    end else begin
      prev <= pin_s;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assert_edge_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_on && !flag |=> !flag);
  assert_level_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sense == SENSE_LOW && !flag |=> !flag);
endmodule

// File: rtl/startup_ctrl.sv
module startup_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_enter,
  input  logic wake_cond,
  output pwr_t state,
  output logic wake,
  output logic term
);
  localparam int unsigned CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYC - 1);

  logic [CW-1:0] cnt;

  assign wake = (state == PWR_SLEEP) & wake_cond;
  assign term = (state == PWR_WARM) & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PWR_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        PWR_RUN:   if (pd_enter) state <= PWR_SLEEP;
        PWR_SLEEP: if (wake) begin
                     state <= PWR_WARM;
                     cnt   <= '0;
                   end
        PWR_WARM:  if (term) state <= PWR_RUN;
                   else      cnt   <= cnt + 1'b1;
        default:   state <= PWR_RUN;
      endcase
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == PWR_WARM |-> cnt <= LAST);
  assert_warm_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> state == PWR_RUN);
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int unsigned N_PC        = 6,
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_clk_en_i,
  input  logic            pd_enter_i,
  input  logic [N_PC-1:0] pc_pins_i,
  input  logic [N_PC-1:0] pc_mask_i,
  input  logic            pc_en_i,
  input  logic            pc_ack_i,
  input  logic            pc_w1c_i,
  input  logic            ext_pin_i,
  input  logic [1:0]      ext_sense_i,
  input  logic            ext_en_i,
  input  logic            ext_ack_i,
  input  logic            ext_w1c_i,
  output logic            pc_irq_o,
  output logic            ext_irq_o,
  output logic            pc_flag_o,
  output logic            ext_flag_o,
  output logic            wake_o,
  output logic            ready_o
);
  sense_t          sense;
  pwr_t            state;
  logic [N_PC-1:0] pc_s, pc_toggle;
  logic            ext_s, ext_hit, io_on, running, level_low, wake_cond, term;

  assign sense = sense_t'(ext_sense_i);

  pin_sync #(.W(N_PC), .RST_VAL('0)) u_pc_sync (
    .clk(clk), .rst_n(rst_n), .d(pc_pins_i), .q(pc_s));
  pin_sync #(.W(1), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin_i), .q(ext_s));

  pc_detect #(.N(N_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .pins_s(pc_s), .mask(pc_mask_i),
    .clr(pc_ack_i | pc_w1c_i), .toggle(pc_toggle), .flag(pc_flag_o));

  ext_sense u_ext (
    .clk(clk), .rst_n(rst_n), .pin_s(ext_s), .sense(sense), .io_on(io_on),
    .clr(ext_ack_i | ext_w1c_i), .hit(ext_hit), .flag(ext_flag_o));

  startup_ctrl #(.STARTUP_CYC(STARTUP_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pd_enter(pd_enter_i), .wake_cond(wake_cond),
    .state(state), .wake(wake_o), .term(term));

  // The I/O clock is stopped in power-down and during start-up.
  assign running   = (state == PWR_RUN);
  assign io_on     = io_clk_en_i & running;
  assign level_low = ext_en_i & (sense == SENSE_LOW) & ~ext_s;
  assign wake_cond = (pc_flag_o & pc_en_i) | level_low;
  assign ready_o   = running;

  // Level requests are not latched: once running, the request is the live pin.
  assign pc_irq_o  = running & pc_en_i & pc_flag_o;
  assign ext_irq_o = running & ext_en_i &
                     ((sense == SENSE_LOW) ? ~ext_s : ext_flag_o);

  assert_quiet_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !pc_irq_o && !ext_irq_o);
  assert_wake_only_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> state == PWR_SLEEP);
  assert_level_unlatched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sense == SENSE_LOW && ext_s |-> !ext_irq_o);
  assert_term_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !term);
  assert_hit_needs_io_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |-> io_clk_en_i);
endmodule

// File: tb/pin_irq_unit_bench.sv
module pin_irq_unit_bench;
  localparam int N  = 6;
  localparam int SU = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_clk_en_i = 1'b1, pd_enter_i = 1'b0;
  logic [N-1:0] pc_pins_i = '0, pc_mask_i = '0;
  logic pc_en_i = 1'b0, pc_ack_i = 1'b0, pc_w1c_i = 1'b0;
  logic ext_pin_i = 1'b1;
  logic [1:0] ext_sense_i = 2'b10;
  logic ext_en_i = 1'b0, ext_ack_i = 1'b0, ext_w1c_i = 1'b0;
  logic pc_irq_o, ext_irq_o, pc_flag_o, ext_flag_o, wake_o, ready_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_irq_unit #(.N_PC(N), .STARTUP_CYC(SU)) u_pin_irq_unit (.*);

  function automatic logic exp_edge(input logic [1:0] s, input logic o, input logic n);
    if (s == 2'b01) return o != n;
    if (s == 2'b10) return o && !n;
    if (s == 2'b11) return !o && n;
    return 1'b0;
  endfunction

  function automatic logic exp_pc(input logic [N-1:0] o, input logic [N-1:0] n,
                                  input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i] && (o[i] != n[i])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clr_pc();
    pc_w1c_i = 1'b1; cyc(1); pc_w1c_i = 1'b0;
  endtask

  task automatic clr_ext();
    ext_ack_i = 1'b1; cyc(1); ext_ack_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    cyc(3); rst_n = 1'b1; cyc(2);
    check(pc_flag_o, 1'b0, "R10 pc_flag");
    check(ext_flag_o, 1'b0, "R10 ext_flag");
    check(pc_irq_o | ext_irq_o, 1'b0, "R10 irqs");
    check(wake_o, 1'b0, "R10 wake");
    check(ready_o, 1'b1, "R10 ready");

    // R1/R2/R6: random pin patterns and masks
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] o, n, m;
      logic e;
      o = pc_pins_i; n = N'($urandom); m = N'($urandom);
      if (it < 4) m = '0;
      pc_en_i = (it % 5) != 0;
      pc_mask_i = m; pc_pins_i = n;
      cyc(3);
      e = exp_pc(o, n, m);
      check(pc_flag_o, e, "R1 pc_flag");
      check(pc_irq_o, e & pc_en_i, "R2 pc_irq");
      if (it % 2) clr_pc(); else begin pc_ack_i = 1'b1; cyc(1); pc_ack_i = 1'b0; end
      check(pc_flag_o, 1'b0, "R6 pc clear");
    end

    // R3/R4: random external edges, I/O clock randomly on or off
    ext_en_i = 1'b1;
    for (int it = 0; it < 60; it++) begin
      logic o, n, io;
      logic [1:0] s;
      s = 2'(1 + ($urandom % 3));
      io = (it % 4) != 0;
      o = ext_pin_i; n = $urandom % 2;
      ext_sense_i = s; io_clk_en_i = io;
      cyc(1);
      ext_pin_i = n;
      cyc(3);
      check(ext_flag_o, io & exp_edge(s, o, n), io ? "R3 ext edge" : "R4 gated edge");
      check(ext_irq_o, io & exp_edge(s, o, n), "R3 ext irq");
      io_clk_en_i = 1'b1;
      if (it % 2) clr_ext(); else begin ext_w1c_i = 1'b1; cyc(1); ext_w1c_i = 1'b0; end
      check(ext_flag_o, 1'b0, "R6 ext clear");
    end

    // R4: edge while clock off is not recognised once clock resumes
    ext_pin_i = 1'b1; ext_sense_i = 2'b10; cyc(4); clr_ext();
    io_clk_en_i = 1'b0; ext_pin_i = 1'b0; cyc(4);
    io_clk_en_i = 1'b1; cyc(4);
    check(ext_flag_o, 1'b0, "R4 lost edge");
    ext_pin_i = 1'b1; cyc(4);

    // R5: level mode follows the pin
    ext_sense_i = 2'b00; cyc(2);
    check(ext_irq_o, 1'b0, "R5 level high");
    ext_pin_i = 1'b0; cyc(1);
    check(ext_irq_o, 1'b0, "R5 sync delay");
    cyc(1);
    check(ext_irq_o, 1'b1, "R5 level low");
    ext_pin_i = 1'b1; cyc(2);
    check(ext_irq_o, 1'b0, "R5 not latched");

    // R7/R8/R9: level wake, level gone before start-up ends
    pc_en_i = 1'b0;
    pd_enter_i = 1'b1; cyc(1); pd_enter_i = 1'b0;
    io_clk_en_i = 1'b0;
    check(ready_o, 1'b0, "R8 asleep");
    cyc(3);
    check(wake_o, 1'b0, "R7 no wake");
    ext_pin_i = 1'b0; cyc(2);
    check(wake_o, 1'b1, "R7 level wake");
    check(ext_irq_o, 1'b0, "R8 irq held asleep");
    ext_pin_i = 1'b1; cyc(5);
    check(ready_o, 1'b0, "R8 warming");
    cyc(SU + 2);
    check(ready_o, 1'b1, "R8 ready");
    check(ext_irq_o, 1'b0, "R9 level lost");

    // R9: level held through start-up
    pd_enter_i = 1'b1; cyc(1); pd_enter_i = 1'b0;
    ext_pin_i = 1'b0; cyc(2);
    check(wake_o, 1'b1, "R7 level wake 2");
    cyc(SU + 4);
    check(ready_o, 1'b1, "R8 ready 2");
    check(ext_irq_o, 1'b1, "R9 level held");
    ext_pin_i = 1'b1; cyc(3);

    // R7/R4/R2: pin-change wake, edge in sleep lost
    ext_sense_i = 2'b10; io_clk_en_i = 1'b1; cyc(2); clr_ext();
    pc_en_i = 1'b1; pc_mask_i = 6'b000100; clr_pc();
    pd_enter_i = 1'b1; cyc(1); pd_enter_i = 1'b0;
    ext_pin_i = 1'b0; cyc(4); ext_pin_i = 1'b1; cyc(4);
    pc_pins_i[2] = ~pc_pins_i[2]; cyc(3);
    check(wake_o, 1'b1, "R7 pc wake");
    check(pc_irq_o, 1'b0, "R8 pc held");
    cyc(SU + 3);
    check(ready_o, 1'b1, "R8 ready 3");
    check(pc_irq_o, 1'b1, "R2 pc after wake");
    check(ext_flag_o, 1'b0, "R4 sleep edge");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule